// File: doc/BRIEF.md
# Camera register initialisation sequencer

This block brings up an image sensor once power-up is complete. It walks a fixed table of steps and drives a 16-bit two-wire register master through a request/done handshake. The steps cover:

- an identity read that is compared against an expected value,
- a reset pulse to the on-chip microcontroller,
- PLL programming with a settling delay,
- leaving standby,
- two refresh commands to the sequencer command variable,
- finally, enabling the output.

The table is built inside the block from parameters. A table entry has a 2-bit opcode, a 16-bit address and a 16-bit data field. There are four kinds of entry:

- a write,
- a read that is compared against the data field,
- a wait, whose data field is a count of milliseconds,
- an indirect variable write. This becomes two bus writes: first the variable address to the address-pointer register, then the value to the data-port register.

The sequencer ends in one of two terminal states. The first is done. The second is error, which reports the number of the step that failed. Either state holds until reset. It raises no further bus requests after that.

Top module: `cam_init_seq`

## Requirements
- R1: After a synchronous active-low reset, `seq_done`, `seq_err`, `busy`, `bus_req` and `err_step` are all 0. While `start` stays low, no bus request is raised.
- R2: Step 0 is a read (`bus_rd`=1) of address 0x3000. If the returned data is not 0x1580, the sequencer enters error with `err_step`=0 and raises no further requests.
- R3: Steps 1 and 2 write 0x0501 and then 0x0500 to address 0x3386.
- R4: Steps 3 to 6 write, in this order: 0x0D85 to 0x3214, 0x8F0B to 0x341E, the divider word to 0x341C, and 0x8F09 to 0x341E. The divider word is N in bits 13:8 and M in bits 7:0; with the defaults M=80 and N=2 it is 0x0250.
- R5: Step 7 is a wait of `WAIT_MS`×`CLKS_PER_MS` clock cycles. It is followed by step 8, which writes 0x8F08 to 0x341E. The request for step 8 starts at least that many cycles after the request for step 6.
- R6: Step 9 writes 0x0008 to 0x3202. Steps 10 and 11 are variable writes of 5 and then 6 to variable 0xA103. Each is issued as two writes: first 0xA103 to 0x338C, then the value to 0x3390.
- R7: Step 12 writes 0x02CC to 0x301A. After that write completes, `seq_done` rises and no further bus request is raised.
- R8: A completion with `bus_err`=1 on any transaction ends the run in error. `err_step` then holds the number of the step (0..12, as listed above) that the transaction belongs to; both halves of a variable write report the same step. No further requests follow.
- R9: `bus_req` stays high with stable `bus_addr`, `bus_wdata` and `bus_rd` until the cycle in which `bus_done` is sampled. It is low in the following cycle.
- R10: `seq_done` and `seq_err` are never high together. Each, once set, holds with an unchanged `err_step` until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Power-up complete; begins the sequence |
| bus_req | output | 1 | Transaction request to the register master |
| bus_rd | output | 1 | 1 = read, 0 = write |
| bus_addr | output | 16 | Register address |
| bus_wdata | output | 16 | Write data |
| bus_done | input | 1 | One-cycle completion pulse |
| bus_err | input | 1 | Valid with `bus_done`; transaction failed |
| bus_rdata | input | 16 | Read data, valid with `bus_done` |
| seq_done | output | 1 | Sequence completed |
| seq_err | output | 1 | Sequence stopped on an error |
| err_step | output | 4 | Index of the failing step |
| busy | output | 1 | Sequence in progress |

## Verification
The bench injects a bus error on every transaction in turn. A design that counted transactions rather than steps would report the wrong index on the second half of a variable write. A design that kept running after an error would show extra requests. An identity mismatch with no bus error checks that the compare, and not only the error flag, stops the run. A design that skipped the wait, or counted it in milliseconds of the wrong length, fails the bound on the gap before the PLL-select write. Varying the responder latency exposes a request that is dropped early, that lingers after its done pulse, or whose address moves while it waits.

// File: rtl/cam_init_pkg.sv
// Shared types for the camera initialisation sequencer.
// Assumes: table length fixed at NSTEP; step index fits IDX_W bits.
package cam_init_pkg;
    typedef enum logic [1:0] {
        OP_WR    = 2'd0,
        OP_RDCMP = 2'd1,
        OP_WAIT  = 2'd2,
        OP_VAR   = 2'd3
    } op_e;

    typedef struct packed {
        op_e         op;
        logic [15:0] addr;
        logic [15:0] data;
    } step_t;

    localparam int NSTEP = 13;
    localparam int IDX_W = $clog2(NSTEP + 1);
    localparam logic [15:0] VAR_PTR_REG  = 16'h338C;
    localparam logic [15:0] VAR_PORT_REG = 16'h3390;
endpackage

// File: rtl/cam_init_rom.sv
// Constant step table. Combinational lookup by step index.
// Assumes: PLL_N fits 6 bits, PLL_M fits 8 bits; indices >= NSTEP return a harmless write entry.
module cam_init_rom
    import cam_init_pkg::*;
#(
    parameter int PLL_M   = 80,
    parameter int PLL_N   = 2,
    parameter int WAIT_MS = 1
) (
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);
    localparam logic [15:0] DIV_WORD = {2'b00, 6'(PLL_N), 8'(PLL_M)};
    localparam logic [15:0] WAIT_CNT = 16'(WAIT_MS);

    // Select the table entry for the current index.
    always_comb begin
        case (idx)
            4'd0:    step = '{op: OP_RDCMP, addr: 16'h3000, data: 16'h1580};
            4'd1:    step = '{op: OP_WR,    addr: 16'h3386, data: 16'h0501};
            4'd2:    step = '{op: OP_WR,    addr: 16'h3386, data: 16'h0500};
            4'd3:    step = '{op: OP_WR,    addr: 16'h3214, data: 16'h0D85};
            4'd4:    step = '{op: OP_WR,    addr: 16'h341E, data: 16'h8F0B};
            4'd5:    step = '{op: OP_WR,    addr: 16'h341C, data: DIV_WORD};
            4'd6:    step = '{op: OP_WR,    addr: 16'h341E, data: 16'h8F09};
            4'd7:    step = '{op: OP_WAIT,  addr: 16'h0000, data: WAIT_CNT};
            4'd8:    step = '{op: OP_WR,    addr: 16'h341E, data: 16'h8F08};
            4'd9:    step = '{op: OP_WR,    addr: 16'h3202, data: 16'h0008};
            4'd10:   step = '{op: OP_VAR,   addr: 16'hA103, data: 16'h0005};
            4'd11:   step = '{op: OP_VAR,   addr: 16'hA103, data: 16'h0006};
            4'd12:   step = '{op: OP_WR,    addr: 16'h301A, data: 16'h02CC};
            default: step = '{op: OP_WR,    addr: 16'h0000, data: 16'h0000};
        endcase
    end
endmodule

// File: rtl/cam_init_timer.sv
// Millisecond delay timer. `load` starts a delay of `ms` milliseconds of CLKS_PER_MS cycles each.
// Assumes: load is not asserted while a delay runs; ms = 0 expires at once.
module cam_init_timer #(
    parameter int CLKS_PER_MS = 24000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [15:0] ms,
    output logic        expired
);
    localparam int CW = $clog2(CLKS_PER_MS + 1);
    localparam logic [CW-1:0] CYC_LAST = CW'(CLKS_PER_MS - 1);

    logic [CW-1:0] cyc;
    logic [15:0]   left;
    logic          run;

    // Count cycles within a millisecond and milliseconds remaining.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc  <= '0;
            left <= '0;
            run  <= 1'b0;
        end else if (load) begin
            cyc  <= '0;
            left <= ms;
            run  <= (ms != 16'd0);
        end else if (run) begin
            if (cyc == CYC_LAST) begin
                cyc  <= '0;
                left <= left - 16'd1;
                if (left == 16'd1) run <= 1'b0;
            end else begin
                cyc <= cyc + 1'b1;
            end
        end
    end

    assign expired = !run;

    // R5
    timer_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (left != 16'd0));
endmodule

// File: rtl/cam_init_ctrl.sv
// Step controller. Fetches entries, runs the bus handshake, splits variable writes,
// compares the identity read, and latches the failing step.
// Assumes: bus_done is a one-cycle pulse answering a held bus_req.
module cam_init_ctrl
    import cam_init_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  step_t            step,
    output logic [IDX_W-1:0] idx,
    output logic             tmr_load,
    output logic [15:0]      tmr_ms,
    input  logic             tmr_expired,
    output logic             bus_req,
    output logic             bus_rd,
    output logic [15:0]      bus_addr,
    output logic [15:0]      bus_wdata,
    input  logic             bus_done,
    input  logic             bus_err,
    input  logic [15:0]      bus_rdata,
    output logic             seq_done,
    output logic             seq_err,
    output logic [IDX_W-1:0] err_step,
    output logic             busy
);
    typedef enum logic [2:0] {S_IDLE, S_FETCH, S_BUS, S_WAIT, S_DONE, S_ERR} st_e;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSTEP);

    st_e  st;
    logic phase;
    logic fail;

    // A completed transaction fails on a bus error or an identity mismatch.
    assign fail = bus_err || (step.op == OP_RDCMP && bus_rdata != step.data);

    // Main sequencing state, step index, variable-write phase and error index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            idx      <= '0;
            phase    <= 1'b0;
            err_step <= '0;
        end else begin
            case (st)
                S_IDLE:  if (start) st <= S_FETCH;
                S_FETCH: begin
                    if (idx == LAST_IDX)        st <= S_DONE;
                    else if (step.op == OP_WAIT) st <= S_WAIT;
                    else                         st <= S_BUS;
                end
                S_BUS: if (bus_done) begin
                    if (fail) begin
                        st       <= S_ERR;
                        err_step <= idx;
                    end else if (step.op == OP_VAR && !phase) begin
                        phase <= 1'b1;
                        st    <= S_FETCH;
                    end else begin
                        phase <= 1'b0;
                        idx   <= idx + 1'b1;
                        st    <= S_FETCH;
                    end
                end
                S_WAIT: if (tmr_expired) begin
                    idx <= idx + 1'b1;
                    st  <= S_FETCH;
                end
                default: st <= st;
            endcase
        end
    end

    // Start the delay timer when a wait entry is fetched.
    assign tmr_load = (st == S_FETCH) && (idx != LAST_IDX) && (step.op == OP_WAIT);
    assign tmr_ms   = step.data;

    // Bus outputs: a variable write sends its address to the pointer register, then its value to the data port.
    always_comb begin
        bus_req   = (st == S_BUS);
        bus_rd    = (step.op == OP_RDCMP);
        bus_addr  = step.addr;
        bus_wdata = step.data;
        if (step.op == OP_VAR) begin
            bus_addr  = phase ? VAR_PORT_REG : VAR_PTR_REG;
            bus_wdata = phase ? step.data : step.addr;
        end
    end

    assign seq_done = (st == S_DONE);
    assign seq_err  = (st == S_ERR);
    assign busy     = (st == S_FETCH) || (st == S_BUS) || (st == S_WAIT);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_rd)));
    // R9
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_done) |=> !bus_req);
    // R10
    term_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_done && seq_err));
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> (seq_err && $stable(err_step)));
    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> (seq_done && !bus_req));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !seq_done && !seq_err) |-> !bus_req);
endmodule

// File: rtl/cam_init_seq.sv
// Top of the camera initialisation sequencer: table, controller and delay timer.
// Assumes: a register master that answers each held request with one bus_done pulse.
module cam_init_seq
    import cam_init_pkg::*;
#(
    parameter int CLKS_PER_MS = 24000,
    parameter int PLL_M       = 80,
    parameter int PLL_N       = 2,
    parameter int WAIT_MS     = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             bus_req,
    output logic             bus_rd,
    output logic [15:0]      bus_addr,
    output logic [15:0]      bus_wdata,
    input  logic             bus_done,
    input  logic             bus_err,
    input  logic [15:0]      bus_rdata,
    output logic             seq_done,
    output logic             seq_err,
    output logic [IDX_W-1:0] err_step,
    output logic             busy
);
    step_t            step;
    logic [IDX_W-1:0] idx;
    logic             tmr_load;
    logic [15:0]      tmr_ms;
    logic             tmr_expired;

    cam_init_rom #(.PLL_M(PLL_M), .PLL_N(PLL_N), .WAIT_MS(WAIT_MS)) u_rom (
        .idx  (idx),
        .step (step)
    );

    cam_init_timer #(.CLKS_PER_MS(CLKS_PER_MS)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .ms      (tmr_ms),
        .expired (tmr_expired)
    );

    cam_init_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .step        (step),
        .idx         (idx),
        .tmr_load    (tmr_load),
        .tmr_ms      (tmr_ms),
        .tmr_expired (tmr_expired),
        .bus_req     (bus_req),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_done    (bus_done),
        .bus_err     (bus_err),
        .bus_rdata   (bus_rdata),
        .seq_done    (seq_done),
        .seq_err     (seq_err),
        .err_step    (err_step),
        .busy        (busy)
    );
endmodule

// File: tb/tb_cam_init_seq.sv
// Bench: a latency-varying register responder, a clean run, an identity mismatch,
// and a bus error injected on every transaction in turn.
module tb_cam_init_seq;
    localparam int CPM = 20;
    localparam int WMS = 2;
    localparam int NTX = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        bus_req, bus_rd;
    logic [15:0] bus_addr, bus_wdata;
    logic        bus_done = 1'b0;
    logic        bus_err = 1'b0;
    logic [15:0] bus_rdata = 16'h0;
    logic        seq_done, seq_err, busy;
    logic [3:0]  err_step;

    int errors = 0;
    int checks = 0;
    int cycle = 0;

    logic [15:0] exp_addr [NTX];
    logic [15:0] exp_data [NTX];
    int          exp_step [NTX];
    logic [15:0] rec_addr [16];
    logic [15:0] rec_data [16];
    logic        rec_rd   [16];
    int          rec_t    [16];
    int          ntx = 0;
    int          err_k = -1;
    int          lat = 1;
    logic [15:0] id_val = 16'h1580;
    logic        unstable = 1'b0;
    logic        late_drop = 1'b0;

    cam_init_seq #(.CLKS_PER_MS(CPM), .WAIT_MS(WMS)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .bus_req(bus_req), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_done(bus_done), .bus_err(bus_err), .bus_rdata(bus_rdata),
        .seq_done(seq_done), .seq_err(seq_err), .err_step(err_step), .busy(busy)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    // Register master model: records each request, waits `lat` cycles, answers once.
    initial begin
        forever begin
            @(negedge clk);
            if (bus_req === 1'b1) begin
                if (ntx < 16) begin
                    rec_addr[ntx] = bus_addr;
                    rec_data[ntx] = bus_wdata;
                    rec_rd[ntx]   = bus_rd;
                    rec_t[ntx]    = cycle;
                end
                ntx++;
                for (int w = 0; w < lat; w++) begin
                    @(negedge clk);
                    if (bus_req !== 1'b1 || bus_addr !== rec_addr[(ntx-1) % 16]) unstable = 1'b1;
                end
                bus_rdata = bus_rd ? id_val : 16'h0;
                bus_err   = ((ntx - 1) == err_k);
                bus_done  = 1'b1;
                @(negedge clk);
                bus_done = 1'b0;
                bus_err  = 1'b0;
                if (bus_req !== 1'b0) late_drop = 1'b1;
            end
        end
    end

    task automatic run_case(input logic [15:0] idv, input int ek, input int l);
        id_val = idv; err_k = ek; lat = l;
        start = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        ntx = 0; unstable = 1'b0; late_drop = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!seq_done && !seq_err && !busy && !bus_req && err_step == 0, "R1 reset outputs",
            {seq_done, seq_err, busy, bus_req}, 0);
        repeat (10) @(negedge clk);
        chk(ntx == 0 && !busy, "R1 no request while start low", ntx, 0);
        start = 1'b1;
        for (int t = 0; t < 2000 && !(seq_done || seq_err); t++) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(!unstable, "R9 request held stable until done", unstable, 0);
        chk(!late_drop, "R9 request low after done", late_drop, 0);
        chk(!(seq_done && seq_err), "R10 done and error exclusive", {seq_done, seq_err}, 1);
    endtask

    initial begin
        exp_addr[0]  = 16'h3000; exp_data[0]  = 16'h0000; exp_step[0]  = 0;
        exp_addr[1]  = 16'h3386; exp_data[1]  = 16'h0501; exp_step[1]  = 1;
        exp_addr[2]  = 16'h3386; exp_data[2]  = 16'h0500; exp_step[2]  = 2;
        exp_addr[3]  = 16'h3214; exp_data[3]  = 16'h0D85; exp_step[3]  = 3;
        exp_addr[4]  = 16'h341E; exp_data[4]  = 16'h8F0B; exp_step[4]  = 4;
        exp_addr[5]  = 16'h341C; exp_data[5]  = (16'd2 << 8) | 16'd80; exp_step[5] = 5;
        exp_addr[6]  = 16'h341E; exp_data[6]  = 16'h8F09; exp_step[6]  = 6;
        exp_addr[7]  = 16'h341E; exp_data[7]  = 16'h8F08; exp_step[7]  = 8;
        exp_addr[8]  = 16'h3202; exp_data[8]  = 16'h0008; exp_step[8]  = 9;
        exp_addr[9]  = 16'h338C; exp_data[9]  = 16'hA103; exp_step[9]  = 10;
        exp_addr[10] = 16'h3390; exp_data[10] = 16'h0005; exp_step[10] = 10;
        exp_addr[11] = 16'h338C; exp_data[11] = 16'hA103; exp_step[11] = 11;
        exp_addr[12] = 16'h3390; exp_data[12] = 16'h0006; exp_step[12] = 11;
        exp_addr[13] = 16'h301A; exp_data[13] = 16'h02CC; exp_step[13] = 12;

        // Clean run: full transaction list, wait length, completion.
        run_case(16'h1580, -1, 2);
        chk(ntx == NTX, "R7 transaction count", ntx, NTX);
        chk(rec_rd[0] == 1'b1 && rec_addr[0] == 16'h3000, "R2 identity read", rec_addr[0], 16'h3000);
        for (int i = 1; i < NTX; i++) begin
            string tag;
            tag = (i <= 2) ? "R3" : (i <= 6) ? "R4" : (i == 7) ? "R5" : (i <= 12) ? "R6" : "R7";
            chk(rec_addr[i] == exp_addr[i] && !rec_rd[i], $sformatf("%s address tx%0d", tag, i),
                rec_addr[i], exp_addr[i]);
            chk(rec_data[i] == exp_data[i], $sformatf("%s data tx%0d", tag, i), rec_data[i], exp_data[i]);
        end
        chk(rec_t[7] - rec_t[6] >= CPM * WMS + 1 && rec_t[7] - rec_t[6] <= CPM * WMS + 2 + 10,
            "R5 PLL settling gap", rec_t[7] - rec_t[6], CPM * WMS);
        chk(seq_done && !seq_err && !busy, "R7 done raised", {seq_done, seq_err}, 2);

        // Identity mismatch without a bus error.
        run_case(16'h1581, -1, 1);
        chk(seq_err && !seq_done, "R2 mismatch gives error", {seq_done, seq_err}, 1);
        chk(err_step == 0, "R2 mismatch step", err_step, 0);
        chk(ntx == 1, "R2 no requests after mismatch", ntx, 1);

        // Bus error on each transaction in turn, with varying latency.
        for (int k = 0; k < NTX; k++) begin
            run_case(16'h1580, k, 1 + (k % 3));
            chk(seq_err && !seq_done, $sformatf("R8 error raised k=%0d", k), {seq_done, seq_err}, 1);
            chk(err_step == exp_step[k], $sformatf("R8 err_step k=%0d", k), err_step, exp_step[k]);
            chk(ntx == k + 1, $sformatf("R8 stop after error k=%0d", k), ntx, k + 1);
            repeat (5) @(negedge clk);
            chk(seq_err && err_step == exp_step[k], $sformatf("R10 error sticky k=%0d", k),
                err_step, exp_step[k]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=0 (cycles)", cycle);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule